// File: doc/BRIEF.md
# Lockstep-Checked SECDED Read Decoder

This block sits on the read path of a 64-bit memory and corrects the words that come out of it. Two copies of a single-error-correct, double-error-detect decoder work on every codeword. The first copy takes the codeword as it arrives. The second copy takes the bitwise complement and produces complemented outputs, so the two copies share almost no signal polarity. Their corrected data and error flags are compared in every cycle in which the input is marked valid. Any disagreement sets a sticky compare alarm.

The block's own control state is the output-valid stage and the compare alarm. Each control bit is held as a pair of flip-flops in which one holds the complement of the other. When a pair loses its complementary relation, a second sticky alarm is set, separate from the compare alarm. A clear input resets both alarms.

Two test inputs let a bench or a built-in test exercise both alarms. One flips a codeword bit inside the first decoder copy only. The other makes one rail of the valid pair capture a non-complementary value.

Top module: `lsecc_lockstep`

## Requirements
- R1: Codeword layout: bits 63:0 carry data. Bit 64+j (j = 0..6) is the XOR of every data bit whose column has bit j set. Bit 71 is the XOR of bits 70:0. The column of data bit i is the (i+1)-th integer, counting up from 3, that is not a power of two. For an error-free codeword with valid_i high, data_o equals the data bits and sec_o = ded_o = 0. These outputs appear one clock after the input.
- R2: If exactly one data bit is flipped, data_o is the original data and sec_o = 1, ded_o = 0.
- R3: If exactly one check bit (bits 71:64) is flipped, data_o is unchanged from the data bits and sec_o = 1, ded_o = 0.
- R4: If exactly two bits are flipped, ded_o = 1 and sec_o = 0. data_o then equals bits 63:0 of the received word, uncorrected.
- R5: valid_o is valid_i delayed by one clock. data_o, sec_o and ded_o keep their values in cycles where valid_i is low.
- R6: With inj_dec_i low, no codeword (clean, single-error or double-error) sets cmp_alarm_o.
- R7: inj_dec_i high together with valid_i sets cmp_alarm_o at the next clock. inj_dec_i high with valid_i low leaves cmp_alarm_o at 0.
- R8: cmp_alarm_o stays at 1 until clr_i is high at a clock edge. It reads 0 after that edge, unless a new mismatch occurs in that cycle, in which case it stays at 1.
- R9: inj_pair_i high at one clock edge sets pair_alarm_o one clock later. The alarm stays set until cleared by clr_i. cmp_alarm_o is not affected.
- R10: After reset, data_o, valid_o, sec_o, ded_o, cmp_alarm_o and pair_alarm_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| cw_i | input | 72 | Received codeword |
| valid_i | input | 1 | cw_i holds a word to decode |
| inj_dec_i | input | 1 | Test: flip codeword bit 0 inside the first decoder copy |
| inj_pair_i | input | 1 | Test: corrupt the complement rail of the valid pair |
| clr_i | input | 1 | Clears both sticky alarms |
| data_o | output | 64 | Corrected data |
| valid_o | output | 1 | data_o and the flags are new this cycle |
| sec_o | output | 1 | A single error was corrected |
| ded_o | output | 1 | A double error was detected |
| cmp_alarm_o | output | 1 | Sticky: the two decoder copies disagreed |
| pair_alarm_o | output | 1 | Sticky: a dual-rail control pair was not complementary |

## Verification
The bench builds the block with its default 64-bit data width and 7 syndrome bits. This puts every column of the code within reach. It covers flips at the lowest and highest data bits, at an inner check bit and at the overall-parity bit, and double flips that mix a data bit with a check bit. The full-width word also makes the compare logic see 66 compared signals. Injection through one decoder copy is always detectable at this width, because flipping one bit toggles the overall parity and therefore the single-error flag of that copy alone.

// File: rtl/lsecc_pkg.sv
package lsecc_pkg;
  localparam int DATA_W = 64;
  localparam int SYN_W  = 7;
  localparam int CW_W   = DATA_W + SYN_W + 1;

  // column of data bit idx: idx-th value from 3 upward that is not a power of two
  function automatic logic [SYN_W-1:0] col_of(input int idx);
    logic [SYN_W-1:0] res;
    int n;
    res = '0;
    n = 0;
    for (int v = 3; v < (1 << SYN_W); v++) begin
      if ((v & (v - 1)) != 0) begin
        if (n == idx) res = v[SYN_W-1:0];
        n++;
      end
    end
    return res;
  endfunction

  // per-row parity of the bit count in that row; syndrome offset seen on a complemented word
  function automatic logic [SYN_W-1:0] inv_offset();
    logic [SYN_W-1:0] k;
    k = '1;
    for (int i = 0; i < DATA_W; i++) k ^= col_of(i);
    return k;
  endfunction

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              sec;
    logic              ded;
  } dec_out_t;
endpackage

// File: rtl/lsecc_dec.sv
module lsecc_dec
  import lsecc_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int SW     = SYN_W,
  parameter bit INVERT = 1'b0
) (
  input  logic [DW+SW:0]  cw_i,
  input  logic            flip_i,
  output logic [DW-1:0]   data_o,
  output logic            sec_o,
  output logic            ded_o
);
  localparam int CWW = DW + SW + 1;
  localparam logic [SW-1:0] KOFF = INVERT ? inv_offset() : '0;

  logic [CWW-1:0] cw;
  logic [SW-1:0]  term [DW];
  logic [SW-1:0]  syn;
  logic           odd;
  logic           sec_t, ded_t;
  logic [DW-1:0]  fix;

  assign cw = cw_i ^ {{(CWW-1){1'b0}}, flip_i};

  genvar gi;
  generate
    for (gi = 0; gi < DW; gi++) begin : g_col
      localparam logic [SW-1:0] COL = col_of(gi);
      assign term[gi] = cw[gi] ? COL : '0;
      assign fix[gi]  = sec_t && (syn == COL);
    end
  endgenerate

  always_comb begin
    syn = cw[DW +: SW] ^ KOFF;
    for (int i = 0; i < DW; i++) syn ^= term[i];
  end

  // word width is even, so overall parity is polarity independent
  assign odd   = ^cw;
  assign sec_t = odd;
  assign ded_t = !odd && (syn != '0);

  assign data_o = cw[DW-1:0] ^ fix;

  generate
    if (INVERT) begin : g_neg
      assign sec_o = ~sec_t;
      assign ded_o = ~ded_t;
    end else begin : g_pos
      assign sec_o = sec_t;
      assign ded_o = ded_t;
    end
  endgenerate
endmodule

// File: rtl/lsecc_dual_rail.sv
module lsecc_dual_rail #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] skew_i,
  output logic [W-1:0] q_o,
  output logic         bad_o
);
  logic [W-1:0] t_q, c_q, t_nxt, c_nxt;

  always_comb begin
    t_nxt = d_i;
    c_nxt = ~d_i ^ skew_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '0;
      c_q <= '1;
    end else begin
      t_q <= t_nxt;
      c_q <= c_nxt;
    end
  end

  assign q_o   = t_q;
  assign bad_o = |(~(t_q ^ c_q));
endmodule

// File: rtl/lsecc_lockstep.sv
module lsecc_lockstep
  import lsecc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = SYN_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW+SW:0]  cw_i,
  input  logic            valid_i,
  input  logic            inj_dec_i,
  input  logic            inj_pair_i,
  input  logic            clr_i,
  output logic [DW-1:0]   data_o,
  output logic            valid_o,
  output logic            sec_o,
  output logic            ded_o,
  output logic            cmp_alarm_o,
  output logic            pair_alarm_o
);
  localparam int CTRL_W = 2;  // [0] valid stage, [1] compare alarm

  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // two diverse decoder copies
  logic [DW-1:0] a_data, b_data_n;
  logic          a_sec, a_ded, b_sec_n, b_ded_n;

  lsecc_dec #(.DW(DW), .SW(SW), .INVERT(1'b0)) u_dec_a (
    .cw_i(cw_i), .flip_i(inj_dec_i),
    .data_o(a_data), .sec_o(a_sec), .ded_o(a_ded)
  );

  lsecc_dec #(.DW(DW), .SW(SW), .INVERT(1'b1)) u_dec_b (
    .cw_i(~cw_i), .flip_i(1'b0),
    .data_o(b_data_n), .sec_o(b_sec_n), .ded_o(b_ded_n)
  );

  dec_out_t res_a, res_b;
  logic     differ;

  assign res_a  = '{data: a_data, sec: a_sec, ded: a_ded};
  assign res_b  = '{data: ~b_data_n, sec: ~b_sec_n, ded: ~b_ded_n};
  assign differ = valid_i && (res_a != res_b);

  // dual-rail control state
  logic [CTRL_W-1:0] ctrl_d, ctrl_skew, ctrl_q;
  logic              ctrl_bad;
  logic              cmp_nxt;

  assign cmp_nxt   = differ | (ctrl_q[1] & ~clr_i);
  assign ctrl_d    = {cmp_nxt, valid_i};
  assign ctrl_skew = {1'b0, inj_pair_i};

  lsecc_dual_rail #(.W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_q_n), .d_i(ctrl_d), .skew_i(ctrl_skew),
    .q_o(ctrl_q), .bad_o(ctrl_bad)
  );

  // datapath and pair alarm registers
  logic [DW-1:0] data_q, data_nxt;
  logic          sec_q, sec_nxt, ded_q, ded_nxt;
  logic          pair_q, pair_nxt;

  always_comb begin
    data_nxt = data_q;
    sec_nxt  = sec_q;
    ded_nxt  = ded_q;
    if (valid_i) begin
      data_nxt = res_a.data;
      sec_nxt  = res_a.sec;
      ded_nxt  = res_a.ded;
    end
    pair_nxt = ctrl_bad | (pair_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      data_q <= '0;
      sec_q  <= 1'b0;
      ded_q  <= 1'b0;
      pair_q <= 1'b0;
    end else begin
      data_q <= data_nxt;
      sec_q  <= sec_nxt;
      ded_q  <= ded_nxt;
      pair_q <= pair_nxt;
    end
  end

  assign data_o       = data_q;
  assign sec_o        = sec_q;
  assign ded_o        = ded_q;
  assign valid_o      = ctrl_q[0];
  assign cmp_alarm_o  = ctrl_q[1];
  assign pair_alarm_o = pair_q;
endmodule

// File: rtl/lsecc_lockstep_chk.sv
module lsecc_lockstep_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid_i,
  input logic          inj_dec_i,
  input logic          clr_i,
  input logic [DW-1:0] data_o,
  input logic          valid_o,
  input logic          sec_o,
  input logic          ded_o,
  input logic          cmp_alarm_o,
  input logic          pair_alarm_o
);
  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !(sec_o && ded_o));

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(data_o) && !valid_o));

  assert_no_false_alarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!inj_dec_i && !cmp_alarm_o) |=> !cmp_alarm_o);

  assert_inject_caught_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && inj_dec_i) |=> cmp_alarm_o);

  assert_cmp_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_alarm_o && !clr_i) |=> cmp_alarm_o);

  assert_pair_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_alarm_o && !clr_i) |=> pair_alarm_o);
endmodule

bind lsecc_lockstep lsecc_lockstep_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .valid_i(valid_i), .inj_dec_i(inj_dec_i),
  .clr_i(clr_i), .data_o(data_o), .valid_o(valid_o), .sec_o(sec_o),
  .ded_o(ded_o), .cmp_alarm_o(cmp_alarm_o), .pair_alarm_o(pair_alarm_o)
);

// File: tb/lsecc_lockstep_bench.sv
module lsecc_lockstep_bench;
  logic        clk;
  logic        rst_n;
  logic [71:0] cw_i;
  logic        valid_i, inj_dec_i, inj_pair_i, clr_i;
  logic [63:0] data_o;
  logic        valid_o, sec_o, ded_o, cmp_alarm_o, pair_alarm_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  lsecc_lockstep u_lsecc_lockstep (
    .clk(clk), .rst_n(rst_n), .cw_i(cw_i), .valid_i(valid_i),
    .inj_dec_i(inj_dec_i), .inj_pair_i(inj_pair_i), .clr_i(clr_i),
    .data_o(data_o), .valid_o(valid_o), .sec_o(sec_o), .ded_o(ded_o),
    .cmp_alarm_o(cmp_alarm_o), .pair_alarm_o(pair_alarm_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // {data, first flipped bit, second flipped bit}; 8'hFF = none
  localparam logic [79:0] VEC [8] = '{
    {64'h0000_0000_0000_0000, 8'hFF, 8'hFF},
    {64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 8'hFF},
    {64'h0123_4567_89AB_CDEF, 8'd0,  8'hFF},
    {64'hDEAD_BEEF_CAFE_F00D, 8'd63, 8'hFF},
    {64'hA5A5_A5A5_A5A5_A5A5, 8'd66, 8'hFF},
    {64'h5A5A_5A5A_5A5A_5A5A, 8'd71, 8'hFF},
    {64'h0F0F_0F0F_0F0F_0F0F, 8'd5,  8'd40},
    {64'h1234_5678_9ABC_DEF0, 8'd10, 8'd68}
  };

  // encoder built from the code definition in R1
  function automatic logic [71:0] enc(input logic [63:0] d);
    logic [6:0]  c;
    logic [71:0] w;
    int n;
    c = '0;
    n = 0;
    for (int v = 3; v < 128; v++) begin
      if (((v & (v - 1)) != 0) && (n < 64)) begin
        if (d[n]) c ^= v[6:0];
        n++;
      end
    end
    w = {1'b0, c, d};
    w[71] = ^w[70:0];
    return w;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] last_data;
    rst_n = 1'b0; cw_i = '0; valid_i = 0; inj_dec_i = 0; inj_pair_i = 0; clr_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();

    // R10 reset state
    check("R10 data", data_o, 64'h0);
    check("R10 flags", {58'h0, valid_o, sec_o, ded_o, cmp_alarm_o, pair_alarm_o}, 64'h0);

    // table walk: R1 R2 R3 R4 R6
    last_data = '0;
    for (int k = 0; k < 8; k++) begin
      logic [63:0] d, expd;
      logic [7:0]  e1, e2;
      logic [71:0] w;
      int nerr;
      d = VEC[k][79:16]; e1 = VEC[k][15:8]; e2 = VEC[k][7:0];
      w = enc(d);
      nerr = 0;
      if (e1 != 8'hFF) begin w[e1] = ~w[e1]; nerr++; end
      if (e2 != 8'hFF) begin w[e2] = ~w[e2]; nerr++; end
      expd = (nerr == 2) ? w[63:0] : d;
      cw_i = w; valid_i = 1'b1;
      step();
      check(nerr == 0 ? "R1 data" : nerr == 2 ? "R4 data" : (e1 > 63) ? "R3 data" : "R2 data",
            data_o, expd);
      check("R1 R2 R3 R4 flags", {62'h0, sec_o, ded_o},
            {62'h0, (nerr == 1) ? 1'b1 : 1'b0, (nerr == 2) ? 1'b1 : 1'b0});
      check("R5 valid_o", {63'h0, valid_o}, 64'h1);
      check("R6 no alarm", {63'h0, cmp_alarm_o}, 64'h0);
      last_data = expd;
    end

    // R5: hold while idle
    cw_i = enc(64'hCAFE_0000_1111_2222); valid_i = 1'b0;
    step();
    check("R5 hold data", data_o, last_data);
    check("R5 valid low", {63'h0, valid_o}, 64'h0);

    // R7: injection without valid has no effect
    inj_dec_i = 1'b1;
    step();
    check("R7 idle inject", {63'h0, cmp_alarm_o}, 64'h0);

    // R7: injection with valid
    cw_i = enc(64'h0000_0000_0000_0000); valid_i = 1'b1;
    step();
    check("R7 inject caught", {63'h0, cmp_alarm_o}, 64'h1);

    // R8: sticky, then cleared
    inj_dec_i = 1'b0; valid_i = 1'b0;
    step();
    check("R8 sticky", {63'h0, cmp_alarm_o}, 64'h1);
    clr_i = 1'b1;
    step();
    clr_i = 1'b0;
    check("R8 cleared", {63'h0, cmp_alarm_o}, 64'h0);

    // R9: dual-rail corruption
    inj_pair_i = 1'b1;
    step();
    inj_pair_i = 1'b0;
    step();
    check("R9 pair alarm", {63'h0, pair_alarm_o}, 64'h1);
    check("R9 cmp untouched", {63'h0, cmp_alarm_o}, 64'h0);
    step();
    check("R9 pair sticky", {63'h0, pair_alarm_o}, 64'h1);
    clr_i = 1'b1;
    step();
    clr_i = 1'b0;
    check("R9 pair cleared", {63'h0, pair_alarm_o}, 64'h0);

    // R6: double error after clearing still raises nothing
    cw_i = enc(64'h8000_0000_0000_0001) ^ 72'h3; valid_i = 1'b1;
    step();
    check("R6 double no alarm", {63'h0, cmp_alarm_o}, 64'h0);
    check("R4 ded", {63'h0, ded_o}, 64'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule